// File: doc/BRIEF.md
# Retro Card-Bus Select Glue

This block is the address-decode glue for an 8-bit card bus whose cards were drawn for a processor with two address spaces, one for memory and one for I/O. A processor with a single flat 64K space drives it. The block captures the processor's address, its read/write line, its clock-phase-valid line and its opcode-fetch line on each rising clock edge. From those captured values it builds separate memory-request and I/O-request strobes and separate read and write strobes. It then drives three chip selects.

One 256-byte page of the flat space, set by a parameter, is given to I/O. An access inside that page raises the I/O request. Any other access raises the memory request. Each chip select has its own decode window, fixed at elaboration. A memory window compares only address bits 15 to 11, so it has 2KB resolution. An I/O window compares only bits 7 to 3 of an I/O-page access, so it has 8-byte resolution.

A window can be limited to reads, to writes or to opcode fetches. This stops a write to a read-only device from switching on that device's bus drivers. A legacy switch turns this limiting off. When two windows overlap, the select with the lower index wins.

Top module: `cardbus_select_glue`

## Requirements
- R1: A memory window compares only captured address bits 15..11 against its base under its mask. Address bits 10..3 have no effect on a memory window.
- R2: An I/O window matches only during an I/O request. It compares only captured address bits 7..3 against its base under its mask.
- R3: During a valid phase, an address whose bits 15..8 equal IO_PAGE drives io_req_n low and mem_req_n high. Every other address drives mem_req_n low and io_req_n high.
- R4: mem_req_n and io_req_n are never low in the same cycle.
- R5: During a valid phase, rd_n is low when cpu_rw is 1 and wr_n is low when cpu_rw is 0. The two strobes are never low together.
- R6: In the cycle after a capture with cpu_phase_valid low, every request, strobe and chip select is high.
- R7: With the default parameters, these selects go low and no others:
  - cs_n[0] for reads of 0x2000–0x2FFF;
  - cs_n[1] for writes of 0x3000–0x3FFF;
  - cs_n[2] for any access to 0xFE10–0xFE17.
- R8: The per-select qualifier is 2 bits: 0 means any access, 1 means read only, 2 means write only, 3 means a read with cpu_fetch_n low. With legacy mode off, an access that fails the qualifier leaves that select high. For example, a write to 0x2000 leaves cs_n[0] high.
- R9: A fetch-qualified select goes low only for a read with cpu_fetch_n low. A read with cpu_fetch_n high leaves it high, and so does a write.
- R10: With LEGACY=1, qualifiers are ignored. With default windows, a write to 0x2000 drives cs_n[0] low.
- R11: When several windows match, only the lowest-indexed one drives its select low. At most one select is low in any cycle.
- R12: Inputs are captured on the rising clock edge and every output follows combinationally from the captured values, one edge after the inputs are applied. While rst_n is low at an edge, the capture holds an idle cycle, so all outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 13 | Processor address bits 15..3; bits 2..0 never affect a select |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_phase_valid | input | 1 | High while the processor drives a valid bus cycle |
| cpu_fetch_n | input | 1 | Low during an opcode fetch |
| mem_req_n | output | 1 | Emulated memory request, active low |
| io_req_n | output | 1 | Emulated I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cs_n | output | 3 | Chip selects, active low, bit i for window i |

## Verification
The assertions assume that rst_n is held low over the first edges, so that the capture registers hold an idle cycle before any property is enabled. They also assume that every input is stable at each rising edge. The properties compare outputs against the inputs of the previous edge, so an input that changes at the edge would make the comparison meaningless. The bench only changes inputs one nanosecond after a rising edge, and it sets every input, including the phase-valid and fetch lines, on every cycle. This means no captured value is ever undefined.

// File: rtl/glue_pkg.sv
// Shared constants and types for the card-bus select glue.
// Assumes a 16-bit flat address space with exactly three chip selects.
package glue_pkg;
    localparam int NUM_CS  = 3;   // chip-select count
    localparam int FIELD_W = 5;   // compared address bits per window
    localparam int ADDR_HI = 15;  // top address bit
    localparam int ADDR_LO = 3;   // lowest address bit the glue looks at

    // Per-select access qualifier (2-bit field per select)
    typedef enum logic [1:0] {
        QUAL_ANY   = 2'd0,
        QUAL_READ  = 2'd1,
        QUAL_WRITE = 2'd2,
        QUAL_FETCH = 2'd3
    } qual_e;

    // Captured bus state, active-high internally
    typedef struct packed {
        logic [ADDR_HI:ADDR_LO] addr;
        logic                   rw;
        logic                   valid;
        logic                   fetch;
    } bus_cap_t;
endpackage

// File: rtl/glue_capture.sv
// Input capture stage: registers the processor bus lines on the rising
// clock edge. Assumes inputs are stable around the edge. Reset is
// synchronous, active low, and loads an idle (invalid) cycle.
module glue_capture
    import glue_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_HI:ADDR_LO] addr_in,
    input  logic                   rw_in,
    input  logic                   valid_in,
    input  logic                   fetch_n_in,
    output bus_cap_t               cap
);
    // Capture bus lines, idle cycle on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap.addr  <= '0;
            cap.rw    <= 1'b1;
            cap.valid <= 1'b0;
            cap.fetch <= 1'b0;
        end else begin
            cap.addr  <= addr_in;
            cap.rw    <= rw_in;
            cap.valid <= valid_in;
            cap.fetch <= ~fetch_n_in;
        end
    end
endmodule

// File: rtl/glue_space_split.sv
// Splits a flat-space access into emulated memory and I/O requests and
// derives read and write strobes from the read/write line and the
// clock-phase-valid line. Assumes IO_PAGE names address bits 15..8.
module glue_space_split
    import glue_pkg::*;
#(
    parameter logic [7:0] IO_PAGE = 8'hFE
) (
    input  bus_cap_t cap,
    output logic     mem_req,
    output logic     io_req,
    output logic     rd,
    output logic     wr
);
    logic in_page;

    // Request and strobe generation
    always_comb begin
        in_page = (cap.addr[ADDR_HI:8] == IO_PAGE);
        io_req  = cap.valid &&  in_page;
        mem_req = cap.valid && !in_page;
        rd      = cap.valid &&  cap.rw;
        wr      = cap.valid && !cap.rw;
    end
endmodule

// File: rtl/glue_window.sv
// One decode window: masked compare of a 5-bit address field against a
// base, gated by the request of its space and an access qualifier.
// Assumes the caller passes the field and request of the chosen space.
module glue_window
    import glue_pkg::*;
#(
    parameter logic [FIELD_W-1:0] BASE   = '0,
    parameter logic [FIELD_W-1:0] MASK   = '1,
    parameter logic [1:0]         QUAL   = 2'd0,
    parameter bit                 LEGACY = 1'b0
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               space_req,
    input  logic               rd,
    input  logic               wr,
    input  logic               fetch,
    output logic               hit
);
    logic addr_ok;
    logic qual_ok;

    // Address compare and qualifier gating
    always_comb begin
        addr_ok = (((field ^ BASE) & MASK) == '0);
        unique case (qual_e'(QUAL))
            QUAL_READ:  qual_ok = rd;
            QUAL_WRITE: qual_ok = wr;
            QUAL_FETCH: qual_ok = rd && fetch;
            default:    qual_ok = 1'b1;
        endcase
        if (LEGACY) qual_ok = 1'b1;
        hit = space_req && addr_ok && qual_ok;
    end
endmodule

// File: rtl/glue_priority.sv
// Fixed-priority resolver: the lowest-indexed hit wins, the others are
// suppressed. Output is a one-hot-or-zero grant vector.
module glue_priority
    import glue_pkg::*;
(
    input  logic [NUM_CS-1:0] hits,
    output logic [NUM_CS-1:0] grant
);
    // Lowest index wins
    always_comb begin
        grant = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hits[i]) grant = NUM_CS'(1) << i;
        end
    end
endmodule

// File: rtl/cardbus_select_glue.sv
// Top of the card-bus select glue. Captures the processor bus, emulates
// separate memory and I/O requests, and drives three active-low chip
// selects from per-select windows fixed at elaboration.
// Assumes a single flat 64K processor space; IO_PAGE is the I/O page.
// Per-select parameters are packed, select i in slice i.
module cardbus_select_glue
    import glue_pkg::*;
#(
    parameter logic [7:0]                IO_PAGE  = 8'hFE,
    parameter logic [NUM_CS-1:0]         CS_SPACE = 3'b100,   // 1 = I/O window
    parameter logic [NUM_CS*FIELD_W-1:0] CS_BASE  = {5'b00010, 5'b00110, 5'b00100},
    parameter logic [NUM_CS*FIELD_W-1:0] CS_MASK  = {5'b11111, 5'b11110, 5'b11110},
    parameter logic [NUM_CS*2-1:0]       CS_QUAL  = {2'd0, 2'd2, 2'd1},
    parameter bit                        LEGACY   = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_HI:ADDR_LO] cpu_addr,
    input  logic                   cpu_rw,
    input  logic                   cpu_phase_valid,
    input  logic                   cpu_fetch_n,
    output logic                   mem_req_n,
    output logic                   io_req_n,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic [NUM_CS-1:0]      cs_n
);
    bus_cap_t            cap;
    logic                mem_req, io_req, rd, wr;
    logic [FIELD_W-1:0]  mem_field, io_field;
    logic [NUM_CS-1:0]   hits, grant;

    glue_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (cpu_addr),
        .rw_in      (cpu_rw),
        .valid_in   (cpu_phase_valid),
        .fetch_n_in (cpu_fetch_n),
        .cap        (cap)
    );

    glue_space_split #(.IO_PAGE(IO_PAGE)) u_split (
        .cap     (cap),
        .mem_req (mem_req),
        .io_req  (io_req),
        .rd      (rd),
        .wr      (wr)
    );

    // Address fields of the two spaces
    always_comb begin
        mem_field = cap.addr[ADDR_HI -: FIELD_W];
        io_field  = cap.addr[7:ADDR_LO];
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_win
        if (CS_SPACE[i]) begin : g_io
            glue_window #(
                .BASE   (CS_BASE[i*FIELD_W +: FIELD_W]),
                .MASK   (CS_MASK[i*FIELD_W +: FIELD_W]),
                .QUAL   (CS_QUAL[i*2 +: 2]),
                .LEGACY (LEGACY)
            ) u_win (
                .field     (io_field),
                .space_req (io_req),
                .rd        (rd),
                .wr        (wr),
                .fetch     (cap.fetch),
                .hit       (hits[i])
            );
        end else begin : g_mem
            glue_window #(
                .BASE   (CS_BASE[i*FIELD_W +: FIELD_W]),
                .MASK   (CS_MASK[i*FIELD_W +: FIELD_W]),
                .QUAL   (CS_QUAL[i*2 +: 2]),
                .LEGACY (LEGACY)
            ) u_win (
                .field     (mem_field),
                .space_req (mem_req),
                .rd        (rd),
                .wr        (wr),
                .fetch     (cap.fetch),
                .hit       (hits[i])
            );
        end
    end

    glue_priority u_prio (
        .hits  (hits),
        .grant (grant)
    );

    // Active-low output drive
    always_comb begin
        mem_req_n = ~mem_req;
        io_req_n  = ~io_req;
        rd_n      = ~rd;
        wr_n      = ~wr;
        cs_n      = ~grant;
    end
endmodule

// File: rtl/glue_checker.sv
// Checker for the card-bus select glue, bound to the top module.
// Relates the top's ports to the inputs captured one edge earlier.
module glue_checker
    import glue_pkg::*;
#(
    parameter logic [7:0] IO_PAGE = 8'hFE
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_HI:ADDR_LO] cpu_addr,
    input logic                   cpu_rw,
    input logic                   cpu_phase_valid,
    input logic                   mem_req_n,
    input logic                   io_req_n,
    input logic                   rd_n,
    input logic                   wr_n,
    input logic [NUM_CS-1:0]      cs_n
);
    // R4: requests mutually exclusive
    assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_req_n && !io_req_n));

    // R5: read and write strobes never together
    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5: strobe follows captured read/write line
    assert_read_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_phase_valid && cpu_rw) |=> (!rd_n && wr_n));

    // R6: idle capture releases everything
    assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_phase_valid |=> (&cs_n && mem_req_n && io_req_n && rd_n && wr_n));

    // R3: I/O page access yields I/O request only
    assert_io_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_phase_valid && cpu_addr[ADDR_HI:8] == IO_PAGE) |=> (!io_req_n && mem_req_n));

    // R11: at most one select active
    assert_single_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R12: a select needs a request in the same cycle
    assert_select_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> (!mem_req_n || !io_req_n));
endmodule

bind cardbus_select_glue glue_checker #(.IO_PAGE(IO_PAGE)) u_glue_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_addr        (cpu_addr),
    .cpu_rw          (cpu_rw),
    .cpu_phase_valid (cpu_phase_valid),
    .mem_req_n       (mem_req_n),
    .io_req_n        (io_req_n),
    .rd_n            (rd_n),
    .wr_n            (wr_n),
    .cs_n            (cs_n)
);

// File: tb/cardbus_select_glue_tb_top.sv
// Directed bench for the card-bus select glue. Three instances share one
// stimulus: default windows (dut_i), overlapping/fetch windows (dut_alt),
// and default windows in legacy mode (dut_leg).
module cardbus_select_glue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rw = 1'b1;
    logic        valid = 1'b0;
    logic        fetch_n = 1'b1;

    logic mreq_d, ioreq_d, rd_d, wr_d;
    logic [2:0] cs_d, cs_a, cs_l;
    logic mreq_a, ioreq_a, rd_a, wr_a, mreq_l, ioreq_l, rd_l, wr_l;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    localparam logic [7:0]  PAGE      = 8'hFE;
    localparam logic [2:0]  D_SPACE   = 3'b100;
    localparam logic [14:0] D_BASE    = {5'b00010, 5'b00110, 5'b00100};
    localparam logic [14:0] D_MASK    = {5'b11111, 5'b11110, 5'b11110};
    localparam logic [5:0]  D_QUAL    = {2'd0, 2'd2, 2'd1};
    localparam logic [2:0]  A_SPACE   = 3'b000;
    localparam logic [14:0] A_BASE    = {5'b00000, 5'b00110, 5'b00100};
    localparam logic [14:0] A_MASK    = {5'b11111, 5'b11110, 5'b11100};
    localparam logic [5:0]  A_QUAL    = {2'd3, 2'd1, 2'd0};

    always #2.5 clk = ~clk;   // 200 MHz

    cardbus_select_glue dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr[15:3]), .cpu_rw(rw),
        .cpu_phase_valid(valid), .cpu_fetch_n(fetch_n),
        .mem_req_n(mreq_d), .io_req_n(ioreq_d), .rd_n(rd_d), .wr_n(wr_d), .cs_n(cs_d));

    cardbus_select_glue #(.CS_SPACE(A_SPACE), .CS_BASE(A_BASE), .CS_MASK(A_MASK),
                          .CS_QUAL(A_QUAL)) dut_alt (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr[15:3]), .cpu_rw(rw),
        .cpu_phase_valid(valid), .cpu_fetch_n(fetch_n),
        .mem_req_n(mreq_a), .io_req_n(ioreq_a), .rd_n(rd_a), .wr_n(wr_a), .cs_n(cs_a));

    cardbus_select_glue #(.LEGACY(1'b1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr[15:3]), .cpu_rw(rw),
        .cpu_phase_valid(valid), .cpu_fetch_n(fetch_n),
        .mem_req_n(mreq_l), .io_req_n(ioreq_l), .rd_n(rd_l), .wr_n(wr_l), .cs_n(cs_l));

    // Reference model of the selects, built from the requirements
    function automatic logic [2:0] ref_cs(input logic [15:0] a, input logic r, input logic v,
                                          input logic f_n, input logic [2:0] sp,
                                          input logic [14:0] base, input logic [14:0] mask,
                                          input logic [5:0] qual, input logic legacy);
        logic io, mem, rdv, wrv, q_ok, req;
        logic [4:0] fld;
        io  = v && (a[15:8] == PAGE);
        mem = v && !io;
        rdv = v && r;
        wrv = v && !r;
        for (int i = 0; i < 3; i++) begin
            fld = sp[i] ? a[7:3] : a[15:11];
            req = sp[i] ? io : mem;
            case (qual[i*2 +: 2])
                2'd1:    q_ok = rdv;
                2'd2:    q_ok = wrv;
                2'd3:    q_ok = rdv && !f_n;
                default: q_ok = 1'b1;
            endcase
            if (legacy) q_ok = 1'b1;
            if (req && q_ok && (((fld ^ base[i*5 +: 5]) & mask[i*5 +: 5]) == 5'd0))
                return ~(3'b001 << i);
        end
        return 3'b111;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (addr %h rw %b valid %b fetch_n %b)",
                     tag, act, exp, addr, rw, valid, fetch_n);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic r, input logic v, input logic f_n);
        addr = a; rw = r; valid = v; fetch_n = f_n;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic access(input logic [15:0] a, input logic r, input logic f_n);
        drive(a, r, 1'b1, f_n);
        step();
    endtask

    // R12 reset state
    task automatic test_reset();
        drive(16'h2000, 1'b1, 1'b1, 1'b0);
        repeat (3) step();
        chk("R12 reset cs_n", {5'd0, cs_d}, 8'h07);
        chk("R12 reset req/strobes", {4'd0, mreq_d, ioreq_d, rd_d, wr_d}, 8'h0F);
        rst_n = 1'b1;
    endtask

    // R12 one-edge latency
    task automatic test_latency();
        drive(16'h0000, 1'b1, 1'b0, 1'b1);
        step();
        drive(16'h2000, 1'b1, 1'b1, 1'b1);
        #1;
        chk("R12 before edge", {5'd0, cs_d}, 8'h07);
        step();
        chk("R12 after edge", {5'd0, cs_d}, 8'h06);
    endtask

    // R6 idle phase
    task automatic test_idle();
        drive(16'hFE10, 1'b0, 1'b0, 1'b0);
        step();
        chk("R6 idle cs_n", {5'd0, cs_d}, 8'h07);
        chk("R6 idle req/strobes", {4'd0, mreq_d, ioreq_d, rd_d, wr_d}, 8'h0F);
        drive(16'h2000, 1'b1, 1'b0, 1'b1);
        step();
        chk("R6 idle legacy cs_n", {5'd0, cs_l}, 8'h07);
    endtask

    // Directed corner cases
    task automatic test_corners();
        access(16'h2ABC, 1'b1, 1'b1); chk("R1 low bits ignored", {5'd0, cs_d}, 8'h06);
        access(16'h27F8, 1'b1, 1'b1); chk("R1 top of 2K block", {5'd0, cs_d}, 8'h06);
        access(16'h1FFF, 1'b1, 1'b1); chk("R1 below window", {5'd0, cs_d}, 8'h07);
        access(16'h2FFF, 1'b1, 1'b1); chk("R7 window top", {5'd0, cs_d}, 8'h06);
        access(16'h3000, 1'b0, 1'b1); chk("R7 write window", {5'd0, cs_d}, 8'h05);
        access(16'hFE10, 1'b1, 1'b1); chk("R2 io start", {5'd0, cs_d}, 8'h03);
        access(16'hFE17, 1'b0, 1'b1); chk("R2 io end", {5'd0, cs_d}, 8'h03);
        access(16'hFE18, 1'b1, 1'b1); chk("R2 past io window", {5'd0, cs_d}, 8'h07);
        access(16'hFD10, 1'b1, 1'b1); chk("R2 outside io page", {5'd0, cs_d}, 8'h07);
        access(16'hFE00, 1'b1, 1'b1); chk("R3 page start", {6'd0, mreq_d, ioreq_d}, 8'h02);
        access(16'hFDFF, 1'b1, 1'b1); chk("R3 below page", {6'd0, mreq_d, ioreq_d}, 8'h01);
        access(16'hFF00, 1'b0, 1'b1); chk("R3 above page", {6'd0, mreq_d, ioreq_d}, 8'h01);
        access(16'h2000, 1'b0, 1'b1); chk("R8 write to read window", {5'd0, cs_d}, 8'h07);
        access(16'h3000, 1'b1, 1'b1); chk("R8 read of write window", {5'd0, cs_d}, 8'h07);
        access(16'h2000, 1'b0, 1'b1); chk("R10 legacy write", {5'd0, cs_l}, 8'h06);
        access(16'h0100, 1'b1, 1'b0); chk("R9 fetch read", {5'd0, cs_a}, 8'h03);
        access(16'h0100, 1'b1, 1'b1); chk("R9 plain read", {5'd0, cs_a}, 8'h07);
        access(16'h0100, 1'b0, 1'b0); chk("R9 write in fetch", {5'd0, cs_a}, 8'h07);
        access(16'h3000, 1'b1, 1'b1); chk("R11 overlap low wins", {5'd0, cs_a}, 8'h06);
        access(16'h1000, 1'b0, 1'b1); chk("R5 write strobe", {6'd0, rd_d, wr_d}, 8'h02);
        access(16'h1000, 1'b1, 1'b1); chk("R5 read strobe", {6'd0, rd_d, wr_d}, 8'h01);
    endtask

    // Full sweep of every address, read and write, against the model
    task automatic test_sweep();
        for (int a = 0; a < 65536; a++) begin
            for (int r = 0; r < 2; r++) begin
                logic [15:0] aa;
                logic io_exp;
                aa = 16'(a);
                access(aa, r[0], aa[4]);
                io_exp = (aa[15:8] == PAGE);
                chk("R7 sweep default", {5'd0, cs_d},
                    {5'd0, ref_cs(aa, r[0], 1'b1, aa[4], D_SPACE, D_BASE, D_MASK, D_QUAL, 1'b0)});
                chk("R11 sweep overlap", {5'd0, cs_a},
                    {5'd0, ref_cs(aa, r[0], 1'b1, aa[4], A_SPACE, A_BASE, A_MASK, A_QUAL, 1'b0)});
                chk("R10 sweep legacy", {5'd0, cs_l},
                    {5'd0, ref_cs(aa, r[0], 1'b1, aa[4], D_SPACE, D_BASE, D_MASK, D_QUAL, 1'b1)});
                chk("R3 sweep requests", {6'd0, mreq_d, ioreq_d}, {6'd0, io_exp, !io_exp});
                chk("R4 sweep exclusive", {7'd0, mreq_d | ioreq_d}, 8'h01);
                chk("R5 sweep strobes", {6'd0, rd_d, wr_d}, {6'd0, !r[0], r[0]});
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 180000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        test_reset();
        test_latency();
        test_idle();
        test_corners();
        test_sweep();
        finish_run();
    end
endmodule